// File: doc/BRIEF.md
# Configuration Frame Scrubber

This block keeps a configuration memory free of accumulated upsets while the user logic that depends on it keeps running. It visits the frames of the memory one after another. For each frame it reads every word back from the live memory, compares each word with the matching word of a golden copy, and rewrites the whole frame from the golden copy if any word differs. A rewritten frame is read back once more to confirm the repair. If it still differs, a sticky flag reports a fault that rewriting cannot clear.

Both memories appear as synchronous single-port RAMs with one cycle of read latency. Their address holds the frame index in the upper bits and the word index in the lower bits. A small register interface lets a host do three things: run the scrubber continuously, request one full pass from idle, or clear the statistics. It also lets the host read the busy state, the pass-done and uncorrectable flags, the number of frames repaired, the number of completed passes and the index of the most recently repaired frame.

Top module: `frame_scrubber`

## Requirements
- R1: After reset the block is idle. All counters and flags read zero, and no enable of either memory is asserted while the block is idle.
- R2: A frame is checked by reading words 0 to NWORDS-1 in ascending order from both memories (address = frame index × 2^WA_W + word index). A clean pass writes nothing and takes exactly NFRAMES×NWORDS live reads.
- R3: If any word of a frame differs from the golden copy, all words of that frame are rewritten with golden data in ascending order. ERRCNT (address 2) then rises by one and LASTERR (address 4) takes the frame index.
- R4: A rewritten frame is read back once more. If it still differs, STATUS bit 2 (uncorrectable) is set and stays set until cleared, and the scrubber moves on to the next frame.
- R5: Writing CTRL (address 0) with bit 1 set while idle starts one pass at frame 0 over all frames, after which the block returns to idle. PASSCNT (address 3) rises by one and STATUS bit 1 (pass done, sticky) is set. The same request is ignored while busy.
- R6: While CTRL bit 0 is set, the scrubber loops over all frames and wraps from the last frame to frame 0. PASSCNT rises by one each time it wraps.
- R7: When CTRL bit 0 is cleared, scrubbing stops only at a frame boundary. A rewrite already in progress is finished and verified first.
- R8: Writing CTRL with bit 2 set zeroes ERRCNT, PASSCNT, LASTERR and both sticky flags. This clear takes priority over any increment in the same cycle.
- R9: Register reads are combinational on reg_addr. Address 0 reads {single-pass pending, continuous enable} in bits 1:0. Address 1 reads STATUS, with bit 0 busy.
- R10: The live memory is never read and written in the same cycle. Every live write is preceded by a golden read one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| cfg_rd_en | output | 1 | Live memory read enable |
| cfg_wr_en | output | 1 | Live memory write enable |
| cfg_addr | output | FA_W+WA_W | Live memory address |
| cfg_wdata | output | DW | Live memory write data |
| cfg_rdata | input | DW | Live memory read data, one cycle after the read |
| gold_rd_en | output | 1 | Golden memory read enable |
| gold_addr | output | FA_W+WA_W | Golden memory address |
| gold_rdata | input | DW | Golden memory read data, one cycle after the read |

## Verification
A host clear of the statistics can land in the same cycle in which the final frame of a pass is judged clean and PASSCNT and the pass-done flag are about to be updated. The bench watches the live read address for the last word of the last frame. It then times its CTRL clear write into the following cycle, which is the evaluation cycle. It judges the result one cycle later: PASSCNT must read zero and STATUS must show only busy, which confirms that the clear won. A second overlap, a stop request landing during a rewrite, is judged from which frames of the live memory are repaired and from the address of the final write.

// File: rtl/frame_scrubber.sv
module frame_scrubber #(
  parameter int NFRAMES = 96,
  parameter int NWORDS  = 16,
  parameter int DW      = 32,
  parameter int CNT_W   = 16,
  localparam int FA_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1,
  localparam int WA_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int AW   = FA_W + WA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          cfg_rd_en,
  output logic          cfg_wr_en,
  output logic [AW-1:0] cfg_addr,
  output logic [DW-1:0] cfg_wdata,
  input  logic [DW-1:0] cfg_rdata,
  output logic          gold_rd_en,
  output logic [AW-1:0] gold_addr,
  input  logic [DW-1:0] gold_rdata
);
  localparam logic [FA_W-1:0] F_LAST = FA_W'(NFRAMES - 1);
  localparam logic [WA_W-1:0] W_LAST = WA_W'(NWORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_EVAL, S_WR, S_WRL} st_t;
  st_t st;

  logic [FA_W-1:0]  frame, last_err;
  logic [WA_W-1:0]  word;
  logic             vfy, mism, single, en, pass_done, uncorr;
  logic [CNT_W-1:0] err_cnt, pass_cnt;

  wire ctrl_wr = reg_wen && reg_addr == 3'd0;
  wire clr     = ctrl_wr && reg_wdata[2];
  wire start   = ctrl_wr && reg_wdata[1];
  wire busy    = st != S_IDLE;
  wire pv      = (st == S_RD && word != '0) || st == S_EVAL;
  wire diff    = pv && (cfg_rdata != gold_rdata);
  wire bad     = mism | diff;
  wire f_last  = frame == F_LAST;
  wire go_on   = en || (single && !f_last);
  wire adv     = st == S_EVAL && (!bad || vfy);
  wire repair  = st == S_EVAL && bad && !vfy;

  wire [WA_W-1:0] wa = (st == S_WRL) ? W_LAST : word - 1'b1;

  assign cfg_rd_en  = st == S_RD;
  assign cfg_wr_en  = (st == S_WR && word != '0) || st == S_WRL;
  assign cfg_addr   = cfg_wr_en ? {frame, wa} : {frame, word};
  assign cfg_wdata  = gold_rdata;
  assign gold_rd_en = st == S_RD || st == S_WR;
  assign gold_addr  = {frame, word};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      frame  <= '0;
      word   <= '0;
      vfy    <= 1'b0;
      mism   <= 1'b0;
      single <= 1'b0;
      en     <= 1'b0;
    end else begin
      if (ctrl_wr) en <= reg_wdata[0];
      case (st)
        S_IDLE: begin
          word <= '0;
          vfy  <= 1'b0;
          if (start) begin
            single <= 1'b1;
            frame  <= '0;
            st     <= S_RD;
          end else if (en) begin
            st <= S_RD;
          end
        end
        S_RD: begin
          mism <= (word == '0) ? 1'b0 : bad;
          if (word == W_LAST) st <= S_EVAL;
          else word <= word + 1'b1;
        end
        S_EVAL: begin
          word <= '0;
          if (repair) begin
            st <= S_WR;
          end else begin
            vfy   <= 1'b0;
            frame <= f_last ? '0 : frame + 1'b1;
            if (f_last) single <= 1'b0;
            st <= go_on ? S_RD : S_IDLE;
          end
        end
        S_WR: begin
          if (word == W_LAST) st <= S_WRL;
          else word <= word + 1'b1;
        end
        S_WRL: begin
          word <= '0;
          vfy  <= 1'b1;
          st   <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_cnt   <= '0;
      pass_cnt  <= '0;
      last_err  <= '0;
      pass_done <= 1'b0;
      uncorr    <= 1'b0;
    end else begin
      if (repair) begin
        err_cnt  <= err_cnt + 1'b1;
        last_err <= frame;
      end
      if (adv && f_last) begin
        pass_cnt  <= pass_cnt + 1'b1;
        pass_done <= 1'b1;
      end
      if (adv && vfy && bad) uncorr <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {30'd0, single, en};
      3'd1:    reg_rdata = {29'd0, uncorr, pass_done, busy};
      3'd2:    reg_rdata = 32'(err_cnt);
      3'd3:    reg_rdata = 32'(pass_cnt);
      3'd4:    reg_rdata = 32'(last_err);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/frame_scrubber_chk.sv
module frame_scrubber_chk #(
  parameter int AW    = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wen,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             busy,
  input logic             cfg_rd_en,
  input logic             cfg_wr_en,
  input logic [AW-1:0]    cfg_addr,
  input logic             gold_rd_en,
  input logic [CNT_W-1:0] err_cnt,
  input logic [CNT_W-1:0] pass_cnt
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cfg_rd_en && !cfg_wr_en && !gold_rd_en));

  assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd_en && cfg_wr_en));

  assert_wr_after_gold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> $past(gold_rd_en));

  assert_wr_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && $past(cfg_wr_en)) |-> cfg_addr == $past(cfg_addr) + 1'b1);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 3'd0 && reg_wdata[2]) |=> (err_cnt == '0 && pass_cnt == '0));

  assert_pass_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_cnt != $past(pass_cnt)) |-> (pass_cnt == $past(pass_cnt) + 1'b1 || pass_cnt == '0));
endmodule

bind frame_scrubber frame_scrubber_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .cfg_rd_en(cfg_rd_en),
  .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .gold_rd_en(gold_rd_en),
  .err_cnt(err_cnt), .pass_cnt(pass_cnt)
);

// File: tb/frame_scrubber_tb.sv
module frame_scrubber_tb;
  localparam int NF = 8, NW = 4, DW = 32, AW = 5, DEPTH = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_wen = 1'b0;
  logic [2:0] reg_addr = 3'd1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cfg_rd_en, cfg_wr_en, gold_rd_en;
  logic [AW-1:0] cfg_addr, gold_addr;
  logic [DW-1:0] cfg_wdata, cfg_rdata, gold_rdata;

  frame_scrubber #(.NFRAMES(NF), .NWORDS(NW), .DW(DW), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_rd_en(cfg_rd_en),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gold_rd_en(gold_rd_en), .gold_addr(gold_addr),
    .gold_rdata(gold_rdata));

  logic [DW-1:0] cfg_mem [DEPTH];
  logic [DW-1:0] gold_mem [DEPTH];
  logic inj_en = 1'b0, stuck_en = 1'b0;
  logic [AW-1:0] inj_addr = '0, stuck_addr = '0, last_wr_addr;
  logic [DW-1:0] inj_mask = '0;
  int overlap = 0, rd_count = 0, nvec = 0, nfail = 0;

  function automatic logic [DW-1:0] gval(int a);
    return 32'hC0DE0000 ^ (32'(a) * 32'h00010101);
  endfunction

  initial for (int i = 0; i < DEPTH; i++) gold_mem[i] = gval(i);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cfg_mem[i] <= gval(i);
    end else begin
      if (cfg_wr_en && !(stuck_en && cfg_addr == stuck_addr)) cfg_mem[cfg_addr] <= cfg_wdata;
      if (inj_en) cfg_mem[inj_addr] <= cfg_mem[inj_addr] ^ inj_mask;
      if (cfg_wr_en) last_wr_addr <= cfg_addr;
      if (cfg_wr_en && cfg_rd_en) overlap <= overlap + 1;
      if (cfg_rd_en) rd_count <= rd_count + 1;
    end
    if (cfg_rd_en) cfg_rdata <= cfg_mem[cfg_addr];
    if (gold_rd_en) gold_rdata <= gold_mem[gold_addr];
  end

  task automatic check(string req, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int diffs();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (cfg_mem[i] != gold_mem[i]) n++;
    return n;
  endfunction

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_addr = 3'd1;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 3'd1;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do begin
      @(negedge clk);
      rd_reg(3'd1, s);
    end while (s[0]);
  endtask

  task automatic inject(int a, logic [DW-1:0] m);
    @(negedge clk);
    inj_addr = AW'(a); inj_mask = m; inj_en = 1'b1;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  // {frame, word, mask}
  localparam logic [47:0] VEC [6] = '{
    {8'd0, 8'd0, 32'h0000_0001},
    {8'd7, 8'd3, 32'h8000_0000},
    {8'd3, 8'd1, 32'h0000_0000},
    {8'd5, 8'd2, 32'hFFFF_FFFF},
    {8'd2, 8'd0, 32'h0000_00F0},
    {8'd7, 8'd0, 32'h0000_0003}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int exp_err, exp_last, rc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(3'd1, v); check("R1 status after reset", v, 0);
    rd_reg(3'd2, v); check("R1 errcnt after reset", v, 0);
    rd_reg(3'd3, v); check("R1 passcnt after reset", v, 0);
    check("R1 idle memory quiet", {cfg_rd_en, cfg_wr_en, gold_rd_en}, 0);

    exp_err = 0; exp_last = 0;
    for (int i = 0; i < 6; i++) begin
      int f = int'(VEC[i][47:40]);
      int w = int'(VEC[i][39:32]);
      inject(f * NW + w, VEC[i][31:0]);
      if (VEC[i][31:0] != 0) begin exp_err++; exp_last = f; end
      wr_reg(3'd0, 32'h2);
      wait_idle();
      rd_reg(3'd2, v); check("R3 errcnt", v, exp_err);
      rd_reg(3'd4, v); check("R3 lasterr", v, exp_last);
      rd_reg(3'd3, v); check("R5 passcnt", v, i + 1);
      rd_reg(3'd1, v); check("R5 status pass done", v, 2);
      check(VEC[i][31:0] == 0 ? "R2 clean frame untouched" : "R3 frame restored", diffs(), 0);
    end

    rc0 = rd_count;
    wr_reg(3'd0, 32'h2);
    repeat (10) @(negedge clk);
    wr_reg(3'd0, 32'h2);
    wait_idle();
    check("R5 start ignored while busy (reads)", rd_count - rc0, NF * NW);
    rd_reg(3'd3, v); check("R5 passcnt single step", v, 7);

    stuck_en = 1'b1; stuck_addr = AW'(4 * NW + 1);
    inject(4 * NW + 1, 32'h0000_0100);
    rc0 = rd_count;
    wr_reg(3'd0, 32'h2);
    wait_idle();
    rd_reg(3'd1, v); check("R4 uncorrectable flag", v, 6);
    check("R4 verify re-read", rd_count - rc0, NF * NW + NW);
    rd_reg(3'd4, v); check("R4 lasterr", v, 4);
    wr_reg(3'd0, 32'h4);
    rd_reg(3'd1, v); check("R8 status cleared", v, 0);
    rd_reg(3'd2, v); check("R8 errcnt cleared", v, 0);
    rd_reg(3'd3, v); check("R8 passcnt cleared", v, 0);
    rd_reg(3'd4, v); check("R8 lasterr cleared", v, 0);
    stuck_en = 1'b0;
    wr_reg(3'd0, 32'h2);
    wait_idle();
    rd_reg(3'd1, v); check("R4 repaired after fault removed", v, 2);
    check("R3 memory clean", diffs(), 0);
    wr_reg(3'd0, 32'h4);

    inject(1 * NW + 2, 32'h0000_0010);
    inject(6 * NW + 0, 32'h0001_0000);
    wr_reg(3'd0, 32'h1);
    rd_reg(3'd0, v); check("R9 ctrl readback", v, 1);
    do @(negedge clk); while (!cfg_wr_en);
    wr_reg(3'd0, 32'h0);
    wait_idle();
    check("R7 only frame 1 repaired", diffs(), 1);
    check("R7 rewrite completed", last_wr_addr, NW * 2 - 1);
    rd_reg(3'd2, v); check("R7 errcnt", v, 1);
    wr_reg(3'd0, 32'h1);
    do begin @(negedge clk); rd_reg(3'd3, v); end while (v < 2);
    check("R6 continuous repairs frame 6", diffs(), 0);
    rd_reg(3'd4, v); check("R6 lasterr", v, 6);
    rd_reg(3'd1, v); check("R9 busy while running", v[0], 1);

    do @(negedge clk); while (!(cfg_rd_en && cfg_addr == AW'(DEPTH - 1)));
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 32'h5; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
    rd_reg(3'd3, v); check("R8 clear wins over pass increment", v, 0);
    rd_reg(3'd1, v); check("R8 pass done cleared in same cycle", v, 1);
    wr_reg(3'd0, 32'h0);
    wait_idle();
    check("R10 no read/write overlap", overlap, 0);
    check("R1 idle after stop", {cfg_rd_en, cfg_wr_en, gold_rd_en}, 0);
    finish_run();
  end
endmodule